// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter, running on the SAR clock. A 3-bit source field chooses what starts a conversion: a software start strobe, an overflow pulse from one of four timers, or an external start pin. The pin is asynchronous, so the block synchronizes it before it looks for a rising edge. After a start, the block drives a track/hold enable and a convert enable. Each conversion takes a fixed number of SAR clocks. When it ends, the block gives a one-clock done pulse and shows the captured result.

There are two tracking policies. In continuous mode, the input is tracked whenever no conversion is running. In low-power mode, the track/hold stays idle and stops tracking until a start arrives. An internal start is then followed by a fixed 3-clock tracking window. With the pin as source, tracking follows the pin: the block tracks while the pin is low and converts on its rising edge. A sleep input turns tracking off in every mode.

The analog comparator and the bit decisions are not modelled. A stub register captures a parallel sample word at the first convert clock and presents it as the result when the conversion completes.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, busy, convEn and done are 0 and result is 0. The source code is 000 and the mode is continuous, so trackEn is 1 while sleepReq is 0.
- R2: Source codes are: 000 = swStart, 001 = timerOvf[0], 010 = timerOvf[2], 011 = timerOvf[1], 101 = timerOvf[3], 100 = extPin rising edge. Codes 110 and 111 select no source.
- R3: In continuous mode (cfgLowPower=0), an internal start sampled at clock edge k makes convEn 1 for the 14 cycles that follow edges k..k+13. trackEn is the inverse of convEn, and the two are never 1 together.
- R4: In low-power mode with an internal source, a start sampled at edge k makes trackEn 1 after edges k..k+2. convEn is then 1 after edges k+3..k+16, so the whole sequence spans 17 cycles.
- R5: In low-power mode with the pin as source, trackEn is 1 while the block is idle and the synchronized pin is low. A pin rise set up before edge e starts conversion after edge e+2, with no tracking clocks (two synchronizer stages, then edge detection).
- R6: In low-power mode with an internal source, trackEn is 0 while the block is idle.
- R7: While sleepReq is 1, trackEn is 0, whatever the state or mode.
- R8: busy is 1 from the edge that accepts a start through the last convert cycle. done is 1 for exactly the one cycle after that, and busy is 0 in that cycle.
- R9: A start that arrives while busy is 1 is ignored: the sequence timing and the done cycle do not change.
- R10: sampleIn is captured on the edge that enters conversion. It appears on result in the done cycle and is held until the next done.
- R11: cfgWe loads cfgSrcSel and cfgLowPower on a clock edge. Pulses on unselected sources are ignored, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SAR clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load configuration |
| cfgSrcSel | input | 3 | Start-source code |
| cfgLowPower | input | 1 | 1 = low-power track-and-hold |
| swStart | input | 1 | Software start strobe |
| timerOvf | input | 4 | Timer overflow pulses, bit n = timer n |
| extPin | input | 1 | Asynchronous external start pin |
| sleepReq | input | 1 | Standby/sleep, forces tracking off |
| sampleIn | input | 10 | Stub sample word |
| trackEn | output | 1 | Track/hold tracking enable |
| convEn | output | 1 | Convert enable |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Last conversion result |

## Verification
The assertions assume that configuration is written only while busy is 0. A mode change in the middle of a sequence could otherwise reshape trackEn and the entry into conversion. They also assume that sleepReq and the start strobes are driven synchronously, away from the clock edge. The stimulus meets both assumptions: it writes configuration only between sequences, and it changes every input on the falling clock edge. It drives the pin at a falling edge too, so the synchronizer latency counted in R5 is exact.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TRACK = 2'd1,
    SEQ_CONV  = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // entering conversion: latch sample
    logic finish;   // last convert clock: publish result
  } seqStrobe_t;

  localparam logic [2:0] SRC_SOFT = 3'b000;
  localparam logic [2:0] SRC_TMR0 = 3'b001;
  localparam logic [2:0] SRC_TMR2 = 3'b010;
  localparam logic [2:0] SRC_TMR1 = 3'b011;
  localparam logic [2:0] SRC_PIN  = 3'b100;
  localparam logic [2:0] SRC_TMR3 = 3'b101;

endpackage

// File: rtl/adc_trig_select.sv
module adc_trig_select
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] srcSel,
  input  logic       swStart,
  input  logic [3:0] timerOvf,
  input  logic       extPin,
  output logic       trigPulse,
  output logic       pinSelected,
  output logic       pinLevel
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pinPrev;
  logic                   pinRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      pinPrev   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], extPin};
      pinPrev   <= syncChain[SYNC_STAGES-1];
    end
  end

  assign pinLevel    = syncChain[SYNC_STAGES-1];
  assign pinRise     = pinLevel && !pinPrev;
  assign pinSelected = (srcSel == SRC_PIN);

  always_comb begin
    unique case (srcSel)
      SRC_SOFT: trigPulse = swStart;
      SRC_TMR0: trigPulse = timerOvf[0];
      SRC_TMR1: trigPulse = timerOvf[1];
      SRC_TMR2: trigPulse = timerOvf[2];
      SRC_TMR3: trigPulse = timerOvf[3];
      SRC_PIN:  trigPulse = pinRise;
      default:  trigPulse = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int TRACK_CLKS = 3,
  parameter int CONV_CLKS  = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPulse,
  input  logic       lowPower,
  input  logic       pinSelected,
  input  logic       pinLevel,
  input  logic       sleepReq,
  output logic       busy,
  output logic       convEn,
  output logic       trackEn,
  output seqStrobe_t strobe
);

  localparam int MAX_CLKS = (TRACK_CLKS > CONV_CLKS) ? TRACK_CLKS : CONV_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] TRACK_LAST = CNT_W'(TRACK_CLKS - 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CLKS - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext      = state;
    cntNext        = cnt + 1'b1;
    strobe.capture = 1'b0;
    strobe.finish  = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        cntNext = '0;
        if (trigPulse) begin
          if (lowPower && !pinSelected) begin
            stateNext = SEQ_TRACK;
          end else begin
            stateNext      = SEQ_CONV;
            strobe.capture = 1'b1;
          end
        end
      end
      SEQ_TRACK: begin
        if (cnt == TRACK_LAST) begin
          stateNext      = SEQ_CONV;
          cntNext        = '0;
          strobe.capture = 1'b1;
        end
      end
      SEQ_CONV: begin
        if (cnt == CONV_LAST) begin
          stateNext     = SEQ_IDLE;
          cntNext       = '0;
          strobe.finish = 1'b1;
        end
      end
      default: begin
        stateNext = SEQ_IDLE;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign busy   = (state != SEQ_IDLE);
  assign convEn = (state == SEQ_CONV);

  always_comb begin
    if (sleepReq)         trackEn = 1'b0;
    else if (!lowPower)   trackEn = (state != SEQ_CONV);
    else if (pinSelected) trackEn = (state == SEQ_IDLE) && !pinLevel;
    else                  trackEn = (state == SEQ_TRACK);
  end

  AST_TRACK_CONV_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(trackEn && convEn)); // R3

  AST_SLEEP_NO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |-> !trackEn); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.finish) |=> busy); // R8

  AST_TRACK_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_TRACK) |-> (cnt <= TRACK_LAST)); // R4

  AST_LP_CONV_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convEn) && lowPower && !pinSelected) |-> ($past(state) == SEQ_TRACK)); // R4

  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    convEn |-> (cnt <= CONV_LAST)); // R3

endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             busy,
  input  logic [RES_W-1:0] sampleIn,
  output logic [RES_W-1:0] result,
  output logic             done
);

  logic [RES_W-1:0] sarReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      if (strobe.capture) sarReg <= sampleIn;
      if (strobe.finish)  result <= sarReg;
      done <= strobe.finish;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R8

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !$past(strobe.finish)) |-> $stable(result)); // R10

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int TRACK_CLKS  = 3,
  parameter int CONV_CLKS   = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSrcSel,
  input  logic             cfgLowPower,
  input  logic             swStart,
  input  logic [3:0]       timerOvf,
  input  logic             extPin,
  input  logic             sleepReq,
  input  logic [RES_W-1:0] sampleIn,
  output logic             trackEn,
  output logic             convEn,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);

  logic [2:0] srcSel;
  logic       lowPower;
  logic       trigPulse, pinSelected, pinLevel;
  seqStrobe_t strobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= SRC_SOFT;
      lowPower <= 1'b0;
    end else if (cfgWe) begin
      srcSel   <= cfgSrcSel;
      lowPower <= cfgLowPower;
    end
  end

  adc_trig_select #(.SYNC_STAGES(SYNC_STAGES)) uTrig (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .swStart(swStart),
    .timerOvf(timerOvf), .extPin(extPin), .trigPulse(trigPulse),
    .pinSelected(pinSelected), .pinLevel(pinLevel)
  );

  adc_seq_ctrl #(.TRACK_CLKS(TRACK_CLKS), .CONV_CLKS(CONV_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .trigPulse(trigPulse), .lowPower(lowPower),
    .pinSelected(pinSelected), .pinLevel(pinLevel), .sleepReq(sleepReq),
    .busy(busy), .convEn(convEn), .trackEn(trackEn), .strobe(strobe)
  );

  adc_seq_datapath #(.RES_W(RES_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .sampleIn(sampleIn), .result(result), .done(done)
  );

endmodule

// File: tb/tb_adc_conv_sequencer.sv
`timescale 1ns/1ps
module tb_adc_conv_sequencer;

  logic       clk = 1'b0;
  logic       rstN, cfgWe, cfgLowPower, swStart, extPin, sleepReq;
  logic [2:0] cfgSrcSel;
  logic [3:0] timerOvf;
  logic [9:0] sampleIn, result;
  logic       trackEn, convEn, busy, done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSrcSel(cfgSrcSel),
    .cfgLowPower(cfgLowPower), .swStart(swStart), .timerOvf(timerOvf),
    .extPin(extPin), .sleepReq(sleepReq), .sampleIn(sampleIn),
    .trackEn(trackEn), .convEn(convEn), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] obs();
    return {busy, convEn, trackEn, done};
  endfunction

  task automatic clearTrig();
    swStart  = 1'b0;
    timerOvf = '0;
  endtask

  task automatic setTrig(input logic [2:0] code, input logic v);
    case (code)
      3'b000: swStart     = v;
      3'b001: timerOvf[0] = v;
      3'b010: timerOvf[2] = v;
      3'b011: timerOvf[1] = v;
      3'b101: timerOvf[3] = v;
      3'b100: extPin      = v;
      default: ;
    endcase
  endtask

  task automatic setCfg(input logic [2:0] code, input logic lp);  // R11
    @(negedge clk);
    cfgWe = 1'b1; cfgSrcSel = code; cfgLowPower = lp;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // internal source sequence; R3/R4 timing, R8 busy/done, R9 retrigger, R10 capture
  task automatic runInternal(input logic [2:0] code, input logic lp, input string req);
    int trk = lp ? 3 : 0;
    int total = trk + 14;
    logic [9:0] firstVal = 10'h2A5 ^ {7'd0, code};
    logic [9:0] secondVal = 10'h15A ^ {7'd0, code};
    logic [3:0] exp;
    setCfg(code, lp);
    sampleIn = firstVal;
    setTrig(code, 1'b1);
    @(posedge clk); #1;
    for (int i = 0; i <= total + 1; i++) begin
      exp[3] = (i < total);
      exp[2] = (i >= trk) && (i < total);
      exp[1] = lp ? (i < trk) : !((i >= trk) && (i < total));
      exp[0] = (i == total);
      check(obs() == exp, $sformatf("%s R8 R9 cycle %0d", req, i), obs(), exp);
      if (i == total)
        check(result == (lp ? secondVal : firstVal), "R10 result", result,
              lp ? secondVal : firstVal);
      @(negedge clk);
      clearTrig();
      if (i == 1) sampleIn = secondVal;
      if (i == 4) setTrig(code, 1'b1);   // R9: start while busy
      @(posedge clk); #1;
    end
    clearTrig();
    check(result == (lp ? secondVal : firstVal), "R10 result held", result,
          lp ? secondVal : firstVal);
  endtask

  task automatic testReset();  // R1
    check(busy == 0 && convEn == 0 && done == 0, "R1 flags", obs(), 4'b0010);
    check(trackEn == 1, "R1 trackEn continuous", trackEn, 1);
    check(result == 0, "R1 result", result, 0);
  endtask

  task automatic testSourceSelect();  // R2, R11
    setCfg(3'b011, 1'b0);           // Timer1 selected
    @(negedge clk);
    timerOvf = 4'b1101;             // all but Timer1
    swStart = 1'b1;
    @(negedge clk); clearTrig();
    idleCycles(2);
    check(busy == 0, "R11 unselected ignored", busy, 0);
    setCfg(3'b110, 1'b0);
    @(negedge clk); timerOvf = 4'hF; swStart = 1'b1;
    @(negedge clk); clearTrig();
    idleCycles(2);
    check(busy == 0, "R2 code 110 none", busy, 0);
    setCfg(3'b111, 1'b0);
    @(negedge clk); timerOvf = 4'hF; swStart = 1'b1;
    @(negedge clk); clearTrig();
    idleCycles(2);
    check(busy == 0, "R2 code 111 none", busy, 0);
  endtask

  task automatic testLpIdle();  // R6
    setCfg(3'b000, 1'b1);
    idleCycles(2);
    check(trackEn == 0, "R6 LP idle no tracking", trackEn, 0);
  endtask

  task automatic testSleep();  // R7
    setCfg(3'b000, 1'b0);
    @(negedge clk); sleepReq = 1'b1;
    #1 check(trackEn == 0, "R7 sleep idle", trackEn, 0);
    swStart = 1'b1;
    @(negedge clk); clearTrig();
    check(convEn == 1 && trackEn == 0, "R7 sleep during conv", {convEn, trackEn}, 2'b10);
    idleCycles(16);
    check(busy == 0 && trackEn == 0, "R7 sleep after conv", {busy, trackEn}, 2'b00);
    sleepReq = 1'b0;
    #1 check(trackEn == 1, "R7 sleep released", trackEn, 1);
  endtask

  task automatic testPinLowPower();  // R5
    logic [3:0] exp;
    setCfg(3'b100, 1'b1);
    extPin = 1'b0;
    idleCycles(3);
    check(trackEn == 1 && busy == 0, "R5 tracking while pin low", obs(), 4'b0010);
    sampleIn = 10'h3C3;
    extPin = 1'b1;
    @(posedge clk); #1;
    check(trackEn == 1, "R5 sync stage1", trackEn, 1);
    @(posedge clk); #1;
    check(obs() == 4'b0000, "R5 pin high, not yet converting", obs(), 4'b0000);
    @(posedge clk); #1;
    for (int i = 0; i <= 15; i++) begin
      exp = (i < 14) ? 4'b1100 : (i == 14 ? 4'b0001 : 4'b0000);
      check(obs() == exp, $sformatf("R5 conv cycle %0d", i), obs(), exp);
      @(posedge clk); #1;
    end
    check(result == 10'h3C3, "R5 R10 pin result", result, 10'h3C3);
    @(negedge clk); extPin = 1'b0;
    @(posedge clk); #1;
    check(trackEn == 0, "R5 pin low stage1", trackEn, 0);
    @(posedge clk); #1;
    check(trackEn == 1, "R5 pin low tracks", trackEn, 1);
  endtask

  task automatic testPinContinuous();  // R5, R3
    setCfg(3'b100, 1'b0);
    extPin = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check(trackEn == 1 && convEn == 0, "R3 continuous tracks before pin conv",
          {trackEn, convEn}, 2'b10);
    @(posedge clk); #1;
    check(convEn == 1 && trackEn == 0, "R5 continuous pin conv start", {convEn, trackEn}, 2'b10);
    @(negedge clk); extPin = 1'b0;
    idleCycles(16);
    check(busy == 0 && trackEn == 1, "R3 continuous idle tracks", {busy, trackEn}, 2'b01);
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgSrcSel = 3'b111; cfgLowPower = 1'b1;
    swStart = 1'b0; timerOvf = '0; extPin = 1'b0; sleepReq = 1'b0; sampleIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    testReset();
    runInternal(3'b000, 1'b0, "R3 R2 soft");
    runInternal(3'b001, 1'b0, "R3 R2 tmr0");
    runInternal(3'b010, 1'b1, "R4 R2 tmr2");
    runInternal(3'b011, 1'b1, "R4 R2 tmr1");
    runInternal(3'b101, 1'b0, "R3 R2 tmr3");
    runInternal(3'b000, 1'b1, "R4 soft");
    testSourceSelect();
    testLpIdle();
    testSleep();
    testPinLowPower();
    testPinContinuous();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule